// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Timer

This block watches a UART receive queue while it runs in queued mode. When characters remain in the queue and the serial line has delivered no new character for a span that depends on the programmed character size, it raises a pending timeout flag. The host interrupt logic can then drain the queue even though the fill-level threshold has not been reached.

The span is measured in bit times. Each bit time is counted as a group of pulses of the 16x oversampling enable. The span grows with the programmed word length. The count restarts when the receiver reports the middle of a stop bit and when the host pops a character. The count and the flag are also cleared while the queue is empty and while queued mode is off. The receiver shifter and the queue storage sit outside this block.

Top module: `rxfifo_idle_timer`

## Requirements
- R1: After reset, `timeoutPending` is 0.
- R2: While `fifoMode` is 0, the counter and the flag are cleared, and `timeoutPending` reads 0 from the next clock onward.
- R3: While `fifoNotEmpty` is 0, the counter and the flag are cleared, and `timeoutPending` reads 0 from the next clock onward.
- R4: A `stopMid` pulse restarts the count from zero and clears a pending flag at the next clock.
- R5: A `fifoRead` pulse restarts the count from zero and clears a pending flag at the next clock.
- R6: The timeout span in bit times is 4 × W + 12. W is the word length selected by `wordLen`: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. The spans are therefore 32, 36, 40 and 44 bit times.
- R7: One bit time is 16 cycles in which `tick16` is high. Cycles in which `tick16` is low do not advance the count.
- R8: `timeoutPending` rises one clock after the `tick16` cycle that completes the span. It then stays 1 until one of the conditions in R2 to R5 clears it.
- R9: If a clear condition and a `tick16` occur in the same cycle, the clear wins, and the count starts from zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | 16x bit-rate enable, one cycle wide |
| wordLen | input | 2 | Word length code: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8 |
| fifoMode | input | 1 | Queued receive mode is on |
| fifoNotEmpty | input | 1 | The receive queue holds at least one character |
| stopMid | input | 1 | Strobe at the middle of a received stop bit |
| fifoRead | input | 1 | Strobe when the host pops the receive queue |
| timeoutPending | output | 1 | Idle timeout flag |

## Verification
A sub-bit or bit counter that fails to clear or that skips a value shows at the port as `timeoutPending` rising too early or too late. The error is visible within one span, which is at most 704 enable pulses. A flag that fails to clear shows one clock after the offending clear condition. The bench keeps a cycle-level reference count of enable pulses since the last clear. It compares the flag against that count on every cycle, so any off-by-one in the span or in the clear priority is reported at the first cycle where the flag differs.

// File: rtl/rxfifo_idle_timer_pkg.sv
package rxfifo_idle_timer_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic restart;  // zero both counters
    logic advance;  // count one 16x enable pulse
  } ctrlStrobes_t;
endpackage

// File: rtl/rxfifo_idle_timer_dp.sv
module rxfifo_idle_timer_dp
  import rxfifo_idle_timer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int WLEN_W        = 2,
  parameter int MIN_WORD      = 5,
  parameter int SPAN_MUL      = 4,
  parameter int SPAN_ADD      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WLEN_W-1:0] wordLen,
  output logic              limitHit
);
  localparam int MAX_WORD  = MIN_WORD + (1 << WLEN_W) - 1;
  localparam int MAX_SPAN  = SPAN_MUL * MAX_WORD + SPAN_ADD;
  localparam int BIT_W     = $clog2(MAX_SPAN + 1);
  localparam int SUB_W     = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(TICKS_PER_BIT - 1);

  logic [SUB_W-1:0] subCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] spanBits;
  logic             bitDone;

  // Span in bit times, from the programmed word length
  always_comb begin
    spanBits = BIT_W'(SPAN_MUL * (MIN_WORD + int'(wordLen)) + SPAN_ADD);
  end

  assign bitDone  = strobes.advance && (subCnt == LAST_SUB);
  assign limitHit = bitDone && (bitCnt == spanBits - BIT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
      bitCnt <= '0;
    end else if (strobes.restart) begin
      subCnt <= '0;
      bitCnt <= '0;
    end else if (strobes.advance) begin
      subCnt <= bitDone ? '0 : subCnt + SUB_W'(1);
      if (bitDone) bitCnt <= bitCnt + BIT_W'(1);
    end
  end
endmodule

// File: rtl/rxfifo_idle_timer_ctrl.sv
module rxfifo_idle_timer_ctrl
  import rxfifo_idle_timer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick16,
  input  logic         fifoMode,
  input  logic         fifoNotEmpty,
  input  logic         stopMid,
  input  logic         fifoRead,
  input  logic         limitHit,
  output ctrlStrobes_t strobes,
  output logic         timeoutPending
);
  logic clearNow;

  // Any clear condition outranks a tick in the same cycle
  assign clearNow = !fifoMode || !fifoNotEmpty || stopMid || fifoRead;

  always_comb begin
    strobes.restart = clearNow;
    strobes.advance = tick16 && !clearNow && !timeoutPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         timeoutPending <= 1'b0;
    else if (clearNow) timeoutPending <= 1'b0;
    else if (limitHit) timeoutPending <= 1'b1;
  end
endmodule

// File: rtl/rxfifo_idle_timer.sv
module rxfifo_idle_timer
  import rxfifo_idle_timer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int WLEN_W        = 2,
  parameter int MIN_WORD      = 5,
  parameter int SPAN_MUL      = 4,
  parameter int SPAN_ADD      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic [WLEN_W-1:0] wordLen,
  input  logic              fifoMode,
  input  logic              fifoNotEmpty,
  input  logic              stopMid,
  input  logic              fifoRead,
  output logic              timeoutPending
);
  ctrlStrobes_t strobes;
  logic         limitHit;

  rxfifo_idle_timer_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .tick16         (tick16),
    .fifoMode       (fifoMode),
    .fifoNotEmpty   (fifoNotEmpty),
    .stopMid        (stopMid),
    .fifoRead       (fifoRead),
    .limitHit       (limitHit),
    .strobes        (strobes),
    .timeoutPending (timeoutPending)
  );

  rxfifo_idle_timer_dp #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .WLEN_W        (WLEN_W),
    .MIN_WORD      (MIN_WORD),
    .SPAN_MUL      (SPAN_MUL),
    .SPAN_ADD      (SPAN_ADD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wordLen  (wordLen),
    .limitHit (limitHit)
  );
endmodule

// File: rtl/rxfifo_idle_timer_chk.sv
module rxfifo_idle_timer_chk #(
  parameter int TICKS_PER_BIT = 16,
  parameter int WLEN_W        = 2,
  parameter int MIN_WORD      = 5,
  parameter int SPAN_MUL      = 4,
  parameter int SPAN_ADD      = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick16,
  input logic [WLEN_W-1:0] wordLen,
  input logic              fifoMode,
  input logic              fifoNotEmpty,
  input logic              stopMid,
  input logic              fifoRead,
  input logic              timeoutPending
);
  logic clr;
  int   tickSeen;
  int   spanTicks;

  assign clr       = !fifoMode || !fifoNotEmpty || stopMid || fifoRead;
  assign spanTicks = TICKS_PER_BIT * (SPAN_MUL * (MIN_WORD + int'(wordLen)) + SPAN_ADD);

  // Independent count of enable pulses since the last clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tickSeen <= 0;
    else if (clr)                       tickSeen <= 0;
    else if (tick16 && !timeoutPending) tickSeen <= tickSeen + 1;
  end

  always @(posedge clk) begin
    if (!rstN) assert_reset_low_R1: assert (!timeoutPending);
  end

  assert_mode_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode |=> !timeoutPending);
  assert_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    !fifoNotEmpty |=> !timeoutPending);
  assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    stopMid |=> !timeoutPending);
  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |=> !timeoutPending);
  // R6, R7: the flag rises exactly when the span of pulses is complete
  assert_span_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutPending) |-> (tickSeen == spanTicks));
  assert_tick_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutPending) |-> $past(tick16));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutPending && !clr) |=> timeoutPending);
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clr && tick16) |=> (!timeoutPending && tickSeen == 0));
endmodule

bind rxfifo_idle_timer rxfifo_idle_timer_chk #(
  .TICKS_PER_BIT (TICKS_PER_BIT),
  .WLEN_W        (WLEN_W),
  .MIN_WORD      (MIN_WORD),
  .SPAN_MUL      (SPAN_MUL),
  .SPAN_ADD      (SPAN_ADD)
) u_chk (.*);

// File: tb/rxfifo_idle_timer_bench.sv
module rxfifo_idle_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] wordLen = 2'd0;
  logic       fifoMode = 1'b0;
  logic       fifoNotEmpty = 1'b0;
  logic       stopMid = 1'b0;
  logic       fifoRead = 1'b0;
  logic       timeoutPending;

  int   vecs = 0;
  int   fails = 0;
  int   refTicks = 0;
  logic refPend = 1'b0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  rxfifo_idle_timer u_rxfifo_idle_timer (
    .clk(clk), .rstN(rstN), .tick16(tick16), .wordLen(wordLen),
    .fifoMode(fifoMode), .fifoNotEmpty(fifoNotEmpty), .stopMid(stopMid),
    .fifoRead(fifoRead), .timeoutPending(timeoutPending)
  );

  // R6, R7: span in 16x pulses from the word length code
  function automatic int spanOf(input logic [1:0] wl);
    return 16 * (4 * (5 + int'(wl)) + 12);
  endfunction

  task automatic check(input string req);
    vecs++;
    if (timeoutPending !== refPend) begin
      fails++;
      $display("FAIL %s: timeoutPending=%b expected=%b", req, timeoutPending, refPend);
    end
  endtask

  // Compare at negedge, apply new inputs, advance the reference model
  task automatic step(input string req, input logic tk, input logic md,
                      input logic ne, input logic sm, input logic rd,
                      input logic [1:0] wl);
    @(negedge clk);
    check(req);
    tick16 = tk; fifoMode = md; fifoNotEmpty = ne; stopMid = sm;
    fifoRead = rd; wordLen = wl;
    if (!md || !ne || sm || rd) begin           // R9: clear wins
      refTicks = 0; refPend = 1'b0;
    end else if (tk && !refPend) begin
      refTicks++;
      if (refTicks == spanOf(wl)) refPend = 1'b1;
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, timeoutPending=%b expected=0", timeoutPending);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] wl;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    step("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);

    // R6, R8: 7-bit word, tick every cycle, 640 pulses to timeout
    step("R6", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2);
    for (int i = 0; i < 660; i++) step("R6", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2);
    // R8: hold while idle
    for (int i = 0; i < 20; i++) step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2);
    // R5: host read clears
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2);

    // R6, R7: 5-bit word, tick every third cycle
    step("R7", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
    for (int i = 0; i < 1560; i++)
      step("R7", (i % 3) == 0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0);
    // R4: stop bit clears
    step("R4", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
    step("R4", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0);

    // R6: 8-bit word span, then R3 empty queue clears
    step("R6", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3);
    for (int i = 0; i < 710; i++) step("R6", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3);
    step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3);
    for (int i = 0; i < 800; i++) step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3);

    // R2: mode off, queue full, ticks keep coming
    for (int i = 0; i < 800; i++) step("R2", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1);

    // R9: clear with tick near the end of the span, then full span again
    step("R9", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1);
    for (int i = 0; i < 575; i++) step("R9", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1);
    step("R9", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1);
    for (int i = 0; i < 580; i++) step("R9", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1);

    // Random mix; word length changes only together with a stop strobe
    void'($urandom(32'h5eed_c0de));
    wl = 2'd2;
    step("R6", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, wl);
    for (int i = 0; i < 40000; i++) begin
      logic tk, md, ne, sm, rd;
      tk = ($urandom % 4) != 0;
      md = ($urandom % 3000) != 0;
      ne = ($urandom % 2500) != 0;
      sm = ($urandom % 2000) == 0;
      rd = ($urandom % 2200) == 0;
      if (sm) wl = 2'($urandom % 4);
      step("R8", tk, md, ne, sm, rd, wl);
    end
    @(negedge clk);
    check("R8");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule